// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds a small pool of decoded operations waiting in front of one functional unit. Each operation arrives on the dispatch port together with two operands. An operand is either a value that is already known, or the tag of the station that will produce it. Waiting operands listen to the common result bus every cycle. When a broadcast tag equals the tag an operand waits on, the operand takes the broadcast data and becomes valid.

An entry whose two operands are both valid asks the functional unit to run it. If several entries are ready, the one dispatched earliest is offered first. When the unit accepts the request, the entry stays occupied but is no longer offered. The entry is released when the result carrying that entry's own tag appears on the result bus. If every entry is occupied, the array raises `full` and ignores dispatch. That is the structural stall.

Top module: `rs_array`

## Requirements
- R1: After reset, `full` is 0, `ex_valid` is 0 and `disp_tag` equals BASE_ID (default 8).
- R2: An operation dispatched with both operands marked ready is requested on the execute port in the next cycle. The request shows its opcode, both operand values and its station tag. Entry i has tag BASE_ID+i.
- R3: An operand dispatched as not ready holds a producer tag in the low 4 bits of its value field. The entry is not requested until a broadcast with that tag arrives. It then holds the broadcast data and is requested in the following cycle.
- R4: A broadcast whose tag matches no waiting operand has no effect on any entry.
- R5: A dispatched operand marked not ready is captured at dispatch if the broadcast in that same cycle carries its tag.
- R6: Among the ready entries, the one dispatched earliest is presented, whatever its index.
- R7: When `ex_grant` is high while `ex_valid` is high, the presented entry is never requested again. In the next cycle the next-oldest ready entry, if any, is presented.
- R8: An entry that has been granted is freed by a broadcast carrying its own tag. `full` falls in the next cycle.
- R9: `full` is 1 exactly when all entries are occupied. A dispatch while `full` is 1 is ignored.
- R10: `disp_tag` shows the tag of the lowest-index free entry. The next accepted dispatch goes to that entry.
- R11: One broadcast wakes every waiting operand with a matching tag, in all entries at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch an operation this cycle |
| disp_op | input | 4 | Opcode of the dispatched operation |
| disp_a_rdy | input | 1 | Operand A is a value (1) or a producer tag (0) |
| disp_a | input | 16 | Operand A value, or tag in bits 3:0 |
| disp_b_rdy | input | 1 | Operand B is a value (1) or a producer tag (0) |
| disp_b | input | 16 | Operand B value, or tag in bits 3:0 |
| full | output | 1 | All entries occupied; dispatch is ignored |
| disp_tag | output | 4 | Tag of the entry the next dispatch will use |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the station that produced the result |
| cdb_data | input | 16 | Result data |
| ex_valid | output | 1 | A ready entry requests execution |
| ex_grant | input | 1 | Functional unit accepts the request |
| ex_op | output | 4 | Opcode of the requested entry |
| ex_a | output | 16 | Operand A of the requested entry |
| ex_b | output | 16 | Operand B of the requested entry |
| ex_tag | output | 4 | Station tag of the requested entry |

## Verification
Dispatch and result broadcast can fall in the same cycle, and so can grant and broadcast. The bench provokes the first case by dispatching an operation whose two operands wait on the very tag being broadcast. It judges the result by whether that entry is requested with the broadcast data one cycle later. In the same stretch, a broadcast frees one entry while another is granted. A new dispatch then checks that the freed slot is the one reused and that age order, not index, picks the next request.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int N_ENT  = 4;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 4;
    localparam int OP_W   = 4;

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] f;
    } opnd_t;

    typedef struct packed {
        logic            busy;
        logic            issued;
        logic [OP_W-1:0] op;
        opnd_t           a;
        opnd_t           b;
    } ent_t;
endpackage

// File: rtl/rs_snoop.sv
module rs_snoop
    import rs_pkg::*;
(
    input  opnd_t             cur,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output opnd_t             nxt
);
    logic hit;
    assign hit = !cur.v && cdb_valid && (cur.f[TAG_W-1:0] == cdb_tag);

    always_comb begin
        nxt = cur;
        if (hit) begin
            nxt.v = 1'b1;
            nxt.f = cdb_data;
        end
    end
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ready,
    input  logic [N-1:0]  busy,
    input  logic          alloc_en,
    input  logic [IW-1:0] alloc_idx,
    output logic [N-1:0]  pick,
    output logic [IW-1:0] pick_idx,
    output logic          any
);
    // older_q[i][j] set: entry i was dispatched before entry j
    logic [N-1:0][N-1:0] older_q, older_d;

    always_comb begin
        older_d = older_q;
        if (alloc_en) begin
            for (int k = 0; k < N; k++) begin
                older_d[k][alloc_idx] = busy[k] && (IW'(k) != alloc_idx);
                older_d[alloc_idx][k] = 1'b0;
            end
        end
    end

    always_comb begin
        pick     = '0;
        pick_idx = '0;
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (ready[j] && older_q[j][i]) blocked = 1'b1;
            end
            pick[i] = ready[i] && !blocked;
        end
        for (int i = 0; i < N; i++) begin
            if (pick[i]) pick_idx = IW'(i);
        end
    end

    assign any = |pick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end
endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter int N       = N_ENT,
    parameter int BASE_ID = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic              disp_a_rdy,
    input  logic [DATA_W-1:0] disp_a,
    input  logic              disp_b_rdy,
    input  logic [DATA_W-1:0] disp_b,
    output logic              full,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              ex_valid,
    input  logic              ex_grant,
    output logic [OP_W-1:0]   ex_op,
    output logic [DATA_W-1:0] ex_a,
    output logic [DATA_W-1:0] ex_b,
    output logic [TAG_W-1:0]  ex_tag
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        ent_t [N-1:0] ents;
    } state_t;

    state_t        state_q, state_d;
    logic [N-1:0]  busy_vec, ready_vec, pick_vec;
    logic [IW-1:0] alloc_idx, pick_idx;
    logic          alloc_found, alloc_fire, grant_fire;
    opnd_t         snp_a [N];
    opnd_t         snp_b [N];
    opnd_t         dsp_a_in, dsp_b_in, dsp_a_nxt, dsp_b_nxt;

    function automatic logic [TAG_W-1:0] ent_id(input int i);
        return TAG_W'(BASE_ID + i);
    endfunction

    // Per-entry status vectors and result-bus snooping of stored operands
    for (genvar g = 0; g < N; g++) begin : g_ent
        assign busy_vec[g]  = state_q.ents[g].busy;
        assign ready_vec[g] = state_q.ents[g].busy && !state_q.ents[g].issued
                              && state_q.ents[g].a.v && state_q.ents[g].b.v;
        rs_snoop u_snp_a (.cur(state_q.ents[g].a), .cdb_valid(cdb_valid),
                          .cdb_tag(cdb_tag), .cdb_data(cdb_data), .nxt(snp_a[g]));
        rs_snoop u_snp_b (.cur(state_q.ents[g].b), .cdb_valid(cdb_valid),
                          .cdb_tag(cdb_tag), .cdb_data(cdb_data), .nxt(snp_b[g]));
    end

    // Same-cycle capture for operands arriving at dispatch
    assign dsp_a_in = '{v: disp_a_rdy, f: disp_a};
    assign dsp_b_in = '{v: disp_b_rdy, f: disp_b};
    rs_snoop u_snp_da (.cur(dsp_a_in), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
                       .cdb_data(cdb_data), .nxt(dsp_a_nxt));
    rs_snoop u_snp_db (.cur(dsp_b_in), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
                       .cdb_data(cdb_data), .nxt(dsp_b_nxt));

    rs_alloc #(.N(N), .IW(IW)) u_alloc (
        .busy (busy_vec),
        .found(alloc_found),
        .idx  (alloc_idx)
    );

    assign alloc_fire = disp_valid && alloc_found;
    assign grant_fire = ex_valid && ex_grant;

    rs_age_pick #(.N(N), .IW(IW)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready_vec),
        .busy     (busy_vec),
        .alloc_en (alloc_fire),
        .alloc_idx(alloc_idx),
        .pick     (pick_vec),
        .pick_idx (pick_idx),
        .any      (ex_valid)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < N; i++) begin
            state_d.ents[i].a = snp_a[i];
            state_d.ents[i].b = snp_b[i];
            if (grant_fire && pick_vec[i]) begin
                state_d.ents[i].issued = 1'b1;
            end
            if (cdb_valid && (cdb_tag == ent_id(i)) &&
                state_q.ents[i].busy && state_q.ents[i].issued) begin
                state_d.ents[i].busy   = 1'b0;
                state_d.ents[i].issued = 1'b0;
            end
            if (alloc_fire && (alloc_idx == IW'(i))) begin
                state_d.ents[i].busy   = 1'b1;
                state_d.ents[i].issued = 1'b0;
                state_d.ents[i].op     = disp_op;
                state_d.ents[i].a      = dsp_a_nxt;
                state_d.ents[i].b      = dsp_b_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign full     = !alloc_found;
    assign disp_tag = TAG_W'(BASE_ID + int'(alloc_idx));
    assign ex_op    = state_q.ents[pick_idx].op;
    assign ex_a     = state_q.ents[pick_idx].a.f;
    assign ex_b     = state_q.ents[pick_idx].b.f;
    assign ex_tag   = TAG_W'(BASE_ID + int'(pick_idx));
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
    parameter int N     = 4,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             full,
    input logic             cdb_valid,
    input logic             ex_valid,
    input logic             ex_grant,
    input logic [TAG_W-1:0] ex_tag,
    input logic [N-1:0]     pick
);
    assert_request_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && !ex_grant |=> ex_valid);

    assert_no_reissue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_grant |=> !(ex_valid && ex_tag == $past(ex_tag)));

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full && !cdb_valid |=> full);

    assert_free_by_cdb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(cdb_valid));

    assert_single_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));
endmodule

bind rs_array rs_array_chk #(.N(N), .TAG_W(rs_pkg::TAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (full),
    .cdb_valid(cdb_valid),
    .ex_valid (ex_valid),
    .ex_grant (ex_grant),
    .ex_tag   (ex_tag),
    .pick     (pick_vec)
);

// File: tb/test_rs_array.sv
`timescale 1ns/1ps
module test_rs_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [3:0]  disp_op = '0;
    logic        disp_a_rdy = 1'b0;
    logic [15:0] disp_a = '0;
    logic        disp_b_rdy = 1'b0;
    logic [15:0] disp_b = '0;
    logic        full;
    logic [3:0]  disp_tag;
    logic        cdb_valid = 1'b0;
    logic [3:0]  cdb_tag = '0;
    logic [15:0] cdb_data = '0;
    logic        ex_valid;
    logic        ex_grant = 1'b0;
    logic [3:0]  ex_op;
    logic [15:0] ex_a, ex_b;
    logic [3:0]  ex_tag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rs_array i_rs_array (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a_rdy(disp_a_rdy), .disp_a(disp_a), .disp_b_rdy(disp_b_rdy),
        .disp_b(disp_b), .full(full), .disp_tag(disp_tag), .cdb_valid(cdb_valid),
        .cdb_tag(cdb_tag), .cdb_data(cdb_data), .ex_valid(ex_valid),
        .ex_grant(ex_grant), .ex_op(ex_op), .ex_a(ex_a), .ex_b(ex_b), .ex_tag(ex_tag)
    );

    typedef struct packed {
        logic dv; logic [3:0] op; logic ar; logic [15:0] a; logic br; logic [15:0] b;
        logic cv; logic [3:0] ct; logic [15:0] cd; logic gnt;
        logic exv; logic [3:0] extag; logic [3:0] exop; logic [15:0] exa; logic [15:0] exb;
        logic full;
    } step_t;

    localparam int NSTEP = 7;
    localparam step_t TBL [NSTEP] = '{
        '{1'b1,4'h1,1'b1,16'h0011,1'b1,16'h0022, 1'b0,4'h0,16'h0000, 1'b0,
          1'b1,4'h8,4'h1,16'h0011,16'h0022, 1'b0},
        '{1'b1,4'h2,1'b0,16'h0002,1'b1,16'h0033, 1'b0,4'h0,16'h0000, 1'b1,
          1'b0,4'h0,4'h0,16'h0000,16'h0000, 1'b0},
        '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000, 1'b1,4'h3,16'hBEEF, 1'b0,
          1'b0,4'h0,4'h0,16'h0000,16'h0000, 1'b0},
        '{1'b1,4'h3,1'b0,16'h0002,1'b0,16'h0002, 1'b1,4'h2,16'h1234, 1'b0,
          1'b1,4'h9,4'h2,16'h1234,16'h0033, 1'b0},
        '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000, 1'b1,4'h8,16'h0F0F, 1'b0,
          1'b1,4'h9,4'h2,16'h1234,16'h0033, 1'b0},
        '{1'b0,4'h0,1'b0,16'h0000,1'b0,16'h0000, 1'b0,4'h0,16'h0000, 1'b1,
          1'b1,4'hA,4'h3,16'h1234,16'h1234, 1'b0},
        '{1'b1,4'h4,1'b1,16'h0005,1'b1,16'h0006, 1'b0,4'h0,16'h0000, 1'b1,
          1'b1,4'h8,4'h4,16'h0005,16'h0006, 1'b0}
    };
    string tbl_req [NSTEP];

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic dv, input logic [3:0] op, input logic ar,
                        input logic [15:0] a, input logic br, input logic [15:0] b,
                        input logic cv, input logic [3:0] ct, input logic [15:0] cd,
                        input logic gnt);
        @(negedge clk);
        disp_valid = dv; disp_op = op; disp_a_rdy = ar; disp_a = a;
        disp_b_rdy = br; disp_b = b; cdb_valid = cv; cdb_tag = ct; cdb_data = cd;
        ex_grant = gnt;
        @(posedge clk);
        #1;
        disp_valid = 1'b0; cdb_valid = 1'b0; ex_grant = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        tbl_req[0] = "R2"; tbl_req[1] = "R3"; tbl_req[2] = "R4"; tbl_req[3] = "R5";
        tbl_req[4] = "R8"; tbl_req[5] = "R7"; tbl_req[6] = "R10";

        do_reset();
        chk("R1", "full", 16'(full), 16'h0);
        chk("R1", "ex_valid", 16'(ex_valid), 16'h0);
        chk("R1", "disp_tag", 16'(disp_tag), 16'h8);

        for (int s = 0; s < NSTEP; s++) begin
            step(TBL[s].dv, TBL[s].op, TBL[s].ar, TBL[s].a, TBL[s].br, TBL[s].b,
                 TBL[s].cv, TBL[s].ct, TBL[s].cd, TBL[s].gnt);
            chk(tbl_req[s], "ex_valid", 16'(ex_valid), 16'(TBL[s].exv));
            chk(tbl_req[s], "full", 16'(full), 16'(TBL[s].full));
            if (TBL[s].exv) begin
                chk(tbl_req[s], "ex_tag", 16'(ex_tag), 16'(TBL[s].extag));
                chk(tbl_req[s], "ex_op", 16'(ex_op), 16'(TBL[s].exop));
                chk(tbl_req[s], "ex_a", ex_a, TBL[s].exa);
                chk(tbl_req[s], "ex_b", ex_b, TBL[s].exb);
            end
        end

        // Fill all entries waiting on tag 1
        do_reset();
        for (int k = 0; k < 4; k++) begin
            chk("R10", "disp_tag", 16'(disp_tag), 16'(8 + k));
            step(1'b1, 4'(5 + k), 1'b0, 16'h0001, 1'b1, 16'(16'h0010 + k),
                 1'b0, 4'h0, 16'h0, 1'b0);
        end
        chk("R9", "full", 16'(full), 16'h1);
        chk("R9", "ex_valid", 16'(ex_valid), 16'h0);
        // Dispatch while full is ignored
        step(1'b1, 4'hF, 1'b1, 16'hAAAA, 1'b1, 16'hBBBB, 1'b0, 4'h0, 16'h0, 1'b0);
        chk("R9", "ex_valid after blocked dispatch", 16'(ex_valid), 16'h0);
        // One broadcast wakes all four
        step(1'b0, 4'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 4'h1, 16'h0077, 1'b0);
        chk("R11", "ex_tag", 16'(ex_tag), 16'h8);
        chk("R11", "ex_a", ex_a, 16'h0077);
        chk("R11", "ex_b", ex_b, 16'h0010);
        for (int k = 1; k < 4; k++) begin
            step(1'b0, 4'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 4'h0, 16'h0, 1'b1);
            chk("R11", "ex_tag next", 16'(ex_tag), 16'(8 + k));
            chk("R11", "ex_a next", ex_a, 16'h0077);
            chk("R7", "ex_op next", 16'(ex_op), 16'(5 + k));
        end
        step(1'b0, 4'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 4'h0, 16'h0, 1'b1);
        chk("R7", "ex_valid all granted", 16'(ex_valid), 16'h0);
        chk("R9", "full still", 16'(full), 16'h1);
        // Free entry 1, refill it with a waiting operation
        step(1'b0, 4'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 4'h9, 16'h0, 1'b0);
        chk("R8", "full after free", 16'(full), 16'h0);
        chk("R10", "disp_tag freed", 16'(disp_tag), 16'h9);
        step(1'b1, 4'h9, 1'b0, 16'h0001, 1'b1, 16'h0099, 1'b0, 4'h0, 16'h0, 1'b0);
        chk("R9", "full refilled", 16'(full), 16'h1);
        // Free entry 0, refill with a ready operation (younger)
        step(1'b0, 4'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 4'h8, 16'h0, 1'b0);
        chk("R10", "disp_tag entry0", 16'(disp_tag), 16'h8);
        step(1'b1, 4'hA, 1'b1, 16'h0A0A, 1'b1, 16'h0B0B, 1'b0, 4'h0, 16'h0, 1'b0);
        chk("R6", "only ready tag", 16'(ex_tag), 16'h8);
        // Wake the older entry 1: age beats index
        step(1'b0, 4'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 4'h1, 16'h0055, 1'b0);
        chk("R6", "oldest tag", 16'(ex_tag), 16'h9);
        chk("R6", "oldest a", ex_a, 16'h0055);
        chk("R6", "oldest op", 16'(ex_op), 16'h9);

        finish_run();
    end
endmodule